// File: doc/BRIEF.md
# Banked Storage Router with Nonvolatile Write-Cycle Gating

This block sits behind a serial bus front end and steers every byte access to one of three storage targets: a small nonvolatile array, a register/SRAM bank, and a test-register bank. Each access carries a 2-bit bank number and a 10-bit byte address. The block answers every request one clock later with a registered accept or refuse flag and, for reads, the data byte. The front end turns a refuse into a negative acknowledge.

Writing a nonvolatile byte starts a long write cycle. The cycle is modelled as a down-counter of a parameterised number of system clocks. While the cycle runs, only the nonvolatile bank is closed. Register and SRAM traffic goes on as normal. Nonvolatile writes are single-byte only: a data byte that continues a block transfer is refused. Block reads are allowed.

Bank numbers are decoded as follows:

| Bank | Target |
|------|--------|
| 0 | nonvolatile array |
| 1 | register/SRAM |
| 2 | test registers |
| 3 | reserved |

Top module: `bank_router`

## Requirements
- R1: Bank 1 reads and writes to addresses below REG_DEPTH are always accepted. A read returns the byte last written to that address.
- R2: A bank 0 write to an address below NV_DEPTH, made with no write cycle running, is accepted and stores the byte. A later read returns that byte.
- R3: An accepted bank 0 write raises nv_busy on the next cycle. nv_busy then stays high for exactly WR_CYCLES cycles.
- R4: Every bank 0 read or write sampled while nv_busy is high is refused (rsp_ack=0) and leaves the array unchanged.
- R5: Bank 1 accesses sampled while nv_busy is high are accepted and behave as in R1.
- R6: A bank 0 write with req_cont=1 (a follow-on byte of a block transfer) is refused, stores nothing and starts no write cycle. A bank 0 read with req_cont=1 is accepted.
- R7: Every access to bank 3 is refused. Every bank 0 access at an address of NV_DEPTH or above is refused and starts no write cycle.
- R8: A bank 2 write is refused and ignored while test_en=0, and accepted while test_en=1. Bank 2 reads below TST_DEPTH are always accepted.
- R9: A bank 2 access at an address of TST_DEPTH or above is refused.
- R10: While reset is high and after it is released, rsp_valid and nv_busy are 0 until a request is made.
- R11: A request sampled with req_valid=1 gives rsp_valid=1 exactly one cycle later. A cycle with no request gives rsp_valid=0. rsp_rdata is 0 for write responses and for refused reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cont | input | 1 | Byte continues a block transfer |
| req_bank | input | 2 | Bank select: 0 nonvolatile, 1 register/SRAM, 2 test, 3 reserved |
| req_addr | input | 10 | Byte address within the bank |
| req_wdata | input | 8 | Write data |
| test_en | input | 1 | Allows writes to bank 2 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_ack | output | 1 | 1 = accepted, 0 = refused (front end NACKs) |
| rsp_rdata | output | 8 | Read data; 0 when the request was a write or was refused |
| nv_busy | output | 1 | A nonvolatile write cycle is in progress |

## Verification
The bench builds the block with WR_CYCLES=12 instead of the millisecond-scale default. At that length it can count the whole busy window one cycle at a time and send requests that land inside it and just after it. The depths keep their defaults: NV_DEPTH=256, REG_DEPTH=1024 and TST_DEPTH=64. With these values the top register address, the first address past the nonvolatile array, and the first address past the test bank can all be used as refuse boundaries.

// File: rtl/bank_router_pkg.sv
package bank_router_pkg;
  typedef enum logic [1:0] {
    BK_NV  = 2'd0,
    BK_REG = 2'd1,
    BK_TST = 2'd2,
    BK_RSV = 2'd3
  } bank_e;
endpackage

// File: rtl/br_byte_ram.sv
// Plain byte store with a registered read port, shaped for block RAM inference.
module br_byte_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/br_nv_store.sv
// Nonvolatile array model: byte store plus a write-cycle timer.
module br_nv_store #(
  parameter int DEPTH     = 256,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 200000,
  localparam int IW       = $clog2(DEPTH),
  localparam int CW       = $clog2(WR_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          busy
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cyc_left;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst)                 cyc_left <= '0;
    else if (we)             cyc_left <= CW'(WR_CYCLES);
    else if (cyc_left != '0) cyc_left <= cyc_left - 1'b1;
  end

  assign busy = (cyc_left != '0);

  // R3: a write cycle only begins because a write was taken
  assert_cycle_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(we));
  // R4: no write may reach the array while a cycle is running
  assert_no_write_busy_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !we);
endmodule

// File: rtl/br_decode.sv
// Per-request routing and accept/refuse decision.
module br_decode
  import bank_router_pkg::*;
#(
  parameter int AW        = 10,
  parameter int NV_DEPTH  = 256,
  parameter int REG_DEPTH = 1024,
  parameter int TST_DEPTH = 64
) (
  input  logic          valid,
  input  logic          write,
  input  logic          cont,
  input  bank_e         bank,
  input  logic [AW-1:0] addr,
  input  logic          test_en,
  input  logic          nv_busy,
  output logic          accept,
  output logic          nv_we,
  output logic          nv_re,
  output logic          reg_we,
  output logic          reg_re,
  output logic          tst_we,
  output logic          tst_re
);
  localparam logic [AW:0] NV_LIM  = (AW+1)'(NV_DEPTH);
  localparam logic [AW:0] REG_LIM = (AW+1)'(REG_DEPTH);
  localparam logic [AW:0] TST_LIM = (AW+1)'(TST_DEPTH);

  logic [AW:0] a_ext;
  assign a_ext = {1'b0, addr};

  always_comb begin
    unique case (bank)
      BK_NV:   accept = valid && (a_ext < NV_LIM) && !nv_busy && !(write && cont);
      BK_REG:  accept = valid && (a_ext < REG_LIM);
      BK_TST:  accept = valid && (a_ext < TST_LIM) && (!write || test_en);
      default: accept = 1'b0;
    endcase
  end

  assign nv_we  = accept && (bank == BK_NV)  &&  write;
  assign nv_re  = accept && (bank == BK_NV)  && !write;
  assign reg_we = accept && (bank == BK_REG) &&  write;
  assign reg_re = accept && (bank == BK_REG) && !write;
  assign tst_we = accept && (bank == BK_TST) &&  write;
  assign tst_re = accept && (bank == BK_TST) && !write;
endmodule

// File: rtl/bank_router.sv
module bank_router
  import bank_router_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 8,
  parameter int NV_DEPTH  = 256,
  parameter int REG_DEPTH = 1024,
  parameter int TST_DEPTH = 64,
  parameter int WR_CYCLES = 200000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_cont,
  input  logic [1:0]    req_bank,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          test_en,
  output logic          rsp_valid,
  output logic          rsp_ack,
  output logic [DW-1:0] rsp_rdata,
  output logic          nv_busy
);
  localparam int NV_IW  = $clog2(NV_DEPTH);
  localparam int REG_IW = $clog2(REG_DEPTH);
  localparam int TST_IW = $clog2(TST_DEPTH);

  bank_e         bank;
  logic          accept, nv_we, nv_re, reg_we, reg_re, tst_we, tst_re;
  logic [DW-1:0] nv_rd, reg_rd, tst_rd;
  logic          rd_ok_q;
  bank_e         sel_q;

  assign bank = bank_e'(req_bank);

  br_decode #(.AW(AW), .NV_DEPTH(NV_DEPTH), .REG_DEPTH(REG_DEPTH), .TST_DEPTH(TST_DEPTH)) u_dec (
    .valid(req_valid), .write(req_write), .cont(req_cont), .bank(bank),
    .addr(req_addr), .test_en(test_en), .nv_busy(nv_busy), .accept(accept),
    .nv_we(nv_we), .nv_re(nv_re), .reg_we(reg_we), .reg_re(reg_re),
    .tst_we(tst_we), .tst_re(tst_re)
  );

  br_nv_store #(.DEPTH(NV_DEPTH), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_nv (
    .clk(clk), .rst(rst), .we(nv_we), .re(nv_re), .addr(req_addr[NV_IW-1:0]),
    .wdata(req_wdata), .rdata(nv_rd), .busy(nv_busy)
  );

  br_byte_ram #(.DEPTH(REG_DEPTH), .DW(DW)) u_reg (
    .clk(clk), .we(reg_we), .re(reg_re), .addr(req_addr[REG_IW-1:0]),
    .wdata(req_wdata), .rdata(reg_rd)
  );

  br_byte_ram #(.DEPTH(TST_DEPTH), .DW(DW)) u_tst (
    .clk(clk), .we(tst_we), .re(tst_re), .addr(req_addr[TST_IW-1:0]),
    .wdata(req_wdata), .rdata(tst_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rd_ok_q   <= 1'b0;
      sel_q     <= BK_RSV;
    end else begin
      rsp_valid <= req_valid;
      rsp_ack   <= accept;
      rd_ok_q   <= accept && !req_write;
      sel_q     <= bank;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (rd_ok_q) begin
      unique case (sel_q)
        BK_NV:   rsp_rdata = nv_rd;
        BK_REG:  rsp_rdata = reg_rd;
        BK_TST:  rsp_rdata = tst_rd;
        default: rsp_rdata = '0;
      endcase
    end
  end

  // R11: one response per request, one cycle later
  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R4: nonvolatile bank is closed during a write cycle
  assert_busy_refuse_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bank == BK_NV && nv_busy) |=> (rsp_valid && !rsp_ack));
  // R5: register traffic is never held off by the nonvolatile cycle
  assert_reg_open_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bank == BK_REG && {1'b0, req_addr} < (AW+1)'(REG_DEPTH)) |=> rsp_ack);
  // R6: follow-on block bytes cannot be written to the array
  assert_block_write_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_cont && bank == BK_NV) |=> !rsp_ack);
  // R7: reserved bank is always refused
  assert_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bank == BK_RSV) |=> !rsp_ack);
endmodule

// File: tb/bank_router_tb_top.sv
`timescale 1ns/1ps
module bank_router_tb_top;
  localparam int WR = 12;

  logic       clk = 1'b0, rst = 1'b1;
  logic       req_valid = 0, req_write = 0, req_cont = 0, test_en = 0;
  logic [1:0] req_bank = 0;
  logic [9:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic       rsp_valid, rsp_ack, nv_busy;
  logic [7:0] rsp_rdata;

  int nchk = 0, nerr = 0, nv_left = 0;
  bit done = 0;
  logic [7:0] nv_m [256];
  logic [7:0] reg_m [1024];
  logic [7:0] tst_m [64];

  bit         q_ack [$];
  logic [7:0] q_dat [$];
  string      q_tag [$];

  always #2.5 clk = ~clk;

  bank_router #(.WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_cont(req_cont), .req_bank(req_bank), .req_addr(req_addr),
    .req_wdata(req_wdata), .test_en(test_en), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .nv_busy(nv_busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected response from the requirements and queues it.
  task automatic req(input bit wr, input bit ct, input int bk, input int ad,
                     input logic [7:0] d, input string tag);
    bit ok;
    logic [7:0] ed;
    case (bk)
      0: ok = (ad < 256) && (nv_left == 0) && !(wr && ct);
      1: ok = (ad < 1024);
      2: ok = (ad < 64) && (!wr || test_en);
      default: ok = 0;
    endcase
    ed = 8'h00;
    if (ok && !wr) ed = (bk == 0) ? nv_m[ad] : (bk == 1) ? reg_m[ad] : tst_m[ad];
    if (ok && wr) begin
      if (bk == 0) nv_m[ad] = d;
      else if (bk == 1) reg_m[ad] = d;
      else tst_m[ad] = d;
    end
    q_ack.push_back(ok); q_dat.push_back(ed); q_tag.push_back(tag);
    req_valid = 1; req_write = wr; req_cont = ct; req_bank = 2'(bk);
    req_addr = 10'(ad); req_wdata = d;
    if (ok && wr && bk == 0) nv_left = WR;
    else if (nv_left > 0) nv_left--;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      req_valid = 0;
      if (nv_left > 0) nv_left--;
      @(negedge clk);
    end
  endtask

  // Monitor: pops expectations as responses appear.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_ack.size() == 0) check(0, "R11 unexpected response", 1, 0);
      else begin
        bit ea; logic [7:0] ed; string t;
        ea = q_ack.pop_front(); ed = q_dat.pop_front(); t = q_tag.pop_front();
        check(rsp_ack === ea, {t, " ack"}, int'(rsp_ack), int'(ea));
        check(rsp_rdata === ed, {t, " data"}, int'(rsp_rdata), int'(ed));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(rsp_valid === 0 && nv_busy === 0, "R10 in reset", int'({rsp_valid, nv_busy}), 0);
    rst = 0;
    @(negedge clk);
    check(rsp_valid === 0 && nv_busy === 0, "R10 after reset", int'({rsp_valid, nv_busy}), 0);

    req(1, 0, 1, 5, 8'hA5, "R1 wr");
    req(1, 0, 1, 1023, 8'h3C, "R1 wr top");
    req(0, 0, 1, 5, 0, "R1 rd");
    req(0, 0, 1, 1023, 0, "R1 rd top");

    req(1, 0, 0, 16, 8'h77, "R2 wr");
    for (int i = 0; i < WR + 2; i++) begin
      check(nv_busy === (nv_left != 0), "R3 busy window", int'(nv_busy), int'(nv_left != 0));
      idle(1);
    end
    req(0, 0, 0, 16, 0, "R2 rd");

    req(1, 0, 0, 32, 8'h11, "R2 wr2");
    req(0, 0, 0, 16, 0, "R4 rd busy");
    req(1, 0, 0, 16, 8'h55, "R4 wr busy");
    req(1, 0, 1, 7, 8'h99, "R5 wr busy");
    req(0, 0, 1, 7, 0, "R5 rd busy");
    req(0, 0, 1, 5, 0, "R5 rd busy2");
    idle(WR);
    check(nv_busy === 0, "R3 idle again", int'(nv_busy), 0);
    req(0, 0, 0, 16, 0, "R4 unchanged");

    req(1, 1, 0, 16, 8'hEE, "R6 cont wr");
    req(0, 0, 0, 16, 0, "R6 no store");
    req(0, 1, 0, 32, 0, "R6 cont rd");
    req(0, 1, 0, 16, 0, "R6 cont rd2");

    req(0, 0, 3, 5, 0, "R7 rsv rd");
    req(1, 0, 3, 5, 8'h12, "R7 rsv wr");
    req(0, 0, 0, 256, 0, "R7 nv oob rd");
    req(1, 0, 0, 1023, 8'h34, "R7 nv oob wr");
    req(0, 0, 0, 32, 0, "R7 no cycle");
    req(0, 0, 1, 5, 0, "R7 reg intact");

    test_en = 0; req(1, 0, 2, 3, 8'hC3, "R8 locked wr");
    test_en = 1; req(1, 0, 2, 3, 8'h5A, "R8 open wr");
    test_en = 0; req(1, 0, 2, 3, 8'hFF, "R8 locked wr2");
    req(0, 0, 2, 3, 0, "R8 rd");
    req(0, 0, 2, 64, 0, "R9 oob rd");
    test_en = 1; req(1, 0, 2, 64, 8'h01, "R9 oob wr");
    test_en = 0;

    idle(3);
    check(rsp_valid === 0, "R11 idle", int'(rsp_valid), 0);
    check(q_ack.size() == 0, "R11 all answered", q_ack.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule